// File: doc/BRIEF.md
# Stacked-Dimension Mesh Router

This block routes single-flit packets through one node of a three-dimensional mesh or cube under dimension-order routing. It does not use a full crossbar. It is a chain of three two-input, two-output switch stages, one for each dimension, in the order Z, Y, X. The chain starts at the host injection port and ends at the host ejection port. Each stage has two inputs: the packet coming up the chain from below, and the packet arriving on its own dimension's link. It sends each packet either out on its own dimension's link or on to the next stage up the chain.

A packet's head flit carries a signed hop count for each dimension. A stage sends a packet out on its link when that dimension's count is non-zero, and moves the count one step toward zero as it does so. When the count is zero, the packet goes up the chain, so every hop in Z is done before any hop in Y, and Y is done before X. Every port uses a valid/ready handshake. Each stage registers both of its outputs, so each stage a packet passes through adds one cycle.

Flit layout, `PAY_W + 3*OFF_W` bits with defaults 8 and 4:
- X count at bits [3:0].
- Y count at [7:4].
- Z count at [11:8].
- Payload above the counts.

Counts are two's complement. The link buses are packed by dimension index, with X = 0, Y = 1 and Z = 2; dimension d occupies bits [d*W +: W] of the data bus.

Top module: `sdr_router`

## Requirements
- R1: A host-injected packet with a non-zero Z count appears on the Z link output on the first clock edge after the one that accepted it.
- R2: A packet leaving on a dimension's link has that dimension's count moved one step toward zero. A positive count is decremented and a negative count is incremented. The payload and the other two counts are unchanged.
- R3: A packet whose counts are all zero passes from host-in to host-out unchanged. It is valid on host-out on the third clock edge after acceptance.
- R4: Dimensions are served in Z, Y, X order. A host packet with Z = 0 and Y ≠ 0 leaves on the Y link two edges after acceptance. With Z = Y = 0 and X ≠ 0 it leaves on the X link three edges after acceptance.
- R5: A packet arriving on a dimension's link input with a non-zero count for that dimension leaves on the same dimension's link output one edge later, with its count stepped.
- R6: A packet arriving on a dimension's link input with a zero count for that dimension moves up the chain. One arriving on the Y input with Y = X = 0 reaches host-out two edges after acceptance.
- R7: When a stage's link input and chain input want the same output in one cycle, the link input is accepted. The chain input's ready is low, and the chain input is accepted on a later edge.
- R8: When a stage's two inputs want different outputs, both are accepted on the same edge.
- R9: An output whose ready is low keeps valid high and its data unchanged. Once its register is full, inputs that target it see ready low.
- R10: After reset, every output valid is low and host-in ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_in_valid | input | 1 | Injection flit valid |
| host_in_ready | output | 1 | Injection flit accepted |
| host_in_data | input | PAY_W+3*OFF_W | Injection flit |
| host_out_valid | output | 1 | Ejection flit valid |
| host_out_ready | input | 1 | Ejection sink ready |
| host_out_data | output | PAY_W+3*OFF_W | Ejection flit |
| link_in_valid | input | 3 | Per-dimension incoming flit valid (X=0, Y=1, Z=2) |
| link_in_ready | output | 3 | Per-dimension incoming flit accepted |
| link_in_data | input | 3*(PAY_W+3*OFF_W) | Per-dimension incoming flits |
| link_out_valid | output | 3 | Per-dimension outgoing flit valid |
| link_out_ready | input | 3 | Per-dimension downstream ready |
| link_out_data | output | 3*(PAY_W+3*OFF_W) | Per-dimension outgoing flits |

## Verification
Each result is due a fixed number of edges after its packet is accepted. That number equals the count of stages the packet crosses: one for the first stage it leaves from, and three for a host packet that goes all the way to host-out. The bench works out the destination, the stepped flit and this count from the requirements. It then records the due cycle as the accepting edge number plus the count minus one. The monitor compares each departure against that cycle, sampling half a period after the edge. Accepting edges are taken from the sampled ready, so a stalled conflict loser gets its due cycle from the edge on which it was actually taken. Packets sent while an output is held back are compared on data and order only.

// File: rtl/sdr_pkg.sv
`timescale 1ns/100ps
package sdr_pkg;
  localparam int NDIM = 3;

  typedef enum logic {
    TGT_UP  = 1'b0,
    TGT_DIM = 1'b1
  } tgt_e;
endpackage

// File: rtl/sdr_rst_sync.sv
`timescale 1ns/100ps
module sdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdr_out_reg.sv
`timescale 1ns/100ps
module sdr_out_reg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;
  logic         load_en;

  always_comb begin
    in_ready = !vld_q || out_ready;
    load_en  = in_valid && in_ready;
    if (load_en)        vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
endmodule

// File: rtl/sdr_elem.sv
`timescale 1ns/100ps
module sdr_elem
  import sdr_pkg::*;
#(
  parameter int PAY_W = 8,
  parameter int OFF_W = 4,
  parameter int DIM   = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stk_in_valid,
  output logic                          stk_in_ready,
  input  logic [PAY_W+NDIM*OFF_W-1:0]   stk_in_data,
  input  logic                          lnk_in_valid,
  output logic                          lnk_in_ready,
  input  logic [PAY_W+NDIM*OFF_W-1:0]   lnk_in_data,
  output logic                          lnk_out_valid,
  input  logic                          lnk_out_ready,
  output logic [PAY_W+NDIM*OFF_W-1:0]   lnk_out_data,
  output logic                          stk_out_valid,
  input  logic                          stk_out_ready,
  output logic [PAY_W+NDIM*OFF_W-1:0]   stk_out_data
);
  localparam int FLIT_W = PAY_W + NDIM*OFF_W;
  localparam int LSB    = DIM*OFF_W;
  localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);

  tgt_e              lnk_tgt, stk_tgt;
  logic              conflict;
  logic              dreg_valid, dreg_ready, ureg_valid, ureg_ready;
  logic [FLIT_W-1:0] dreg_src, dreg_data, ureg_data;
  logic [OFF_W-1:0]  src_off;

  always_comb begin
    lnk_tgt = (lnk_in_data[LSB +: OFF_W] != '0) ? TGT_DIM : TGT_UP;
    stk_tgt = (stk_in_data[LSB +: OFF_W] != '0) ? TGT_DIM : TGT_UP;
    conflict = lnk_in_valid && (lnk_tgt == stk_tgt);

    lnk_in_ready = (lnk_tgt == TGT_DIM) ? dreg_ready : ureg_ready;
    stk_in_ready = !conflict && ((stk_tgt == TGT_DIM) ? dreg_ready : ureg_ready);

    dreg_valid = (lnk_in_valid && lnk_tgt == TGT_DIM) ||
                 (stk_in_valid && stk_tgt == TGT_DIM && !conflict);
    dreg_src   = (lnk_in_valid && lnk_tgt == TGT_DIM) ? lnk_in_data : stk_in_data;
    src_off    = dreg_src[LSB +: OFF_W];
    dreg_data  = dreg_src;
    dreg_data[LSB +: OFF_W] = src_off[OFF_W-1] ? (src_off + OFF_ONE) : (src_off - OFF_ONE);

    ureg_valid = (lnk_in_valid && lnk_tgt == TGT_UP) ||
                 (stk_in_valid && stk_tgt == TGT_UP && !conflict);
    ureg_data  = (lnk_in_valid && lnk_tgt == TGT_UP) ? lnk_in_data : stk_in_data;
  end

  sdr_out_reg #(.W(FLIT_W)) dim_reg_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dreg_valid), .in_ready(dreg_ready), .in_data(dreg_data),
    .out_valid(lnk_out_valid), .out_ready(lnk_out_ready), .out_data(lnk_out_data)
  );

  sdr_out_reg #(.W(FLIT_W)) up_reg_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ureg_valid), .in_ready(ureg_ready), .in_data(ureg_data),
    .out_valid(stk_out_valid), .out_ready(stk_out_ready), .out_data(stk_out_data)
  );

  AST_LINK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stk_in_valid && lnk_in_valid && lnk_in_ready && (lnk_tgt == stk_tgt) |-> !stk_in_ready); // R7
  AST_UP_DIM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stk_out_valid |-> (stk_out_data[LSB +: OFF_W] == '0)); // R3
endmodule

// File: rtl/sdr_router.sv
`timescale 1ns/100ps
module sdr_router
  import sdr_pkg::*;
#(
  parameter int PAY_W = 8,
  parameter int OFF_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               host_in_valid,
  output logic                               host_in_ready,
  input  logic [PAY_W+NDIM*OFF_W-1:0]        host_in_data,
  output logic                               host_out_valid,
  input  logic                               host_out_ready,
  output logic [PAY_W+NDIM*OFF_W-1:0]        host_out_data,
  input  logic [NDIM-1:0]                    link_in_valid,
  output logic [NDIM-1:0]                    link_in_ready,
  input  logic [NDIM*(PAY_W+NDIM*OFF_W)-1:0] link_in_data,
  output logic [NDIM-1:0]                    link_out_valid,
  input  logic [NDIM-1:0]                    link_out_ready,
  output logic [NDIM*(PAY_W+NDIM*OFF_W)-1:0] link_out_data
);
  localparam int FLIT_W = PAY_W + NDIM*OFF_W;

  logic              rst_sync_n;
  logic              chain_v [NDIM+1];
  logic              chain_r [NDIM+1];
  logic [FLIT_W-1:0] chain_d [NDIM+1];

  sdr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign chain_v[0]     = host_in_valid;
  assign chain_d[0]     = host_in_data;
  assign host_in_ready  = chain_r[0];
  assign host_out_valid = chain_v[NDIM];
  assign host_out_data  = chain_d[NDIM];
  assign chain_r[NDIM]  = host_out_ready;

  for (genvar s = 0; s < NDIM; s++) begin : g_stage
    localparam int D = NDIM - 1 - s;
    sdr_elem #(.PAY_W(PAY_W), .OFF_W(OFF_W), .DIM(D)) elem_i (
      .clk(clk), .rst_n(rst_sync_n),
      .stk_in_valid(chain_v[s]), .stk_in_ready(chain_r[s]), .stk_in_data(chain_d[s]),
      .lnk_in_valid(link_in_valid[D]), .lnk_in_ready(link_in_ready[D]),
      .lnk_in_data(link_in_data[D*FLIT_W +: FLIT_W]),
      .lnk_out_valid(link_out_valid[D]), .lnk_out_ready(link_out_ready[D]),
      .lnk_out_data(link_out_data[D*FLIT_W +: FLIT_W]),
      .stk_out_valid(chain_v[s+1]), .stk_out_ready(chain_r[s+1]), .stk_out_data(chain_d[s+1])
    );
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !host_out_valid && (link_out_valid == '0)); // R10
endmodule

// File: tb/sdr_router_tb_top.sv
`timescale 1ns/100ps
module sdr_router_tb_top;
  localparam int PAY_W = 8;
  localparam int OFF_W = 4;
  localparam int FW    = PAY_W + 3*OFF_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            host_in_valid, host_in_ready, host_out_valid, host_out_ready;
  logic [FW-1:0]   host_in_data, host_out_data;
  logic [2:0]      link_in_valid, link_in_ready, link_out_valid, link_out_ready;
  logic [3*FW-1:0] link_in_data, link_out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  typedef struct {
    int            port;
    logic [FW-1:0] flit;
    int            due;
    string         req;
  } exp_t;
  exp_t sbq[$];

  sdr_router #(.PAY_W(PAY_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_in_valid(host_in_valid), .host_in_ready(host_in_ready), .host_in_data(host_in_data),
    .host_out_valid(host_out_valid), .host_out_ready(host_out_ready), .host_out_data(host_out_data),
    .link_in_valid(link_in_valid), .link_in_ready(link_in_ready), .link_in_data(link_in_data),
    .link_out_valid(link_out_valid), .link_out_ready(link_out_ready), .link_out_data(link_out_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [FW-1:0] mk(input int pay, input int z, input int y, input int x);
    logic [7:0] p = 8'(pay);
    logic [3:0] zz = 4'(z);
    logic [3:0] yy = 4'(y);
    logic [3:0] xx = 4'(x);
    return {p, zz, yy, xx};
  endfunction

  // Expected route from the requirements: stages Z(2),Y(1),X(0), ports 0..2 links, 3 host.
  task automatic model(input int src, input logic [FW-1:0] f,
                       output int port, output logic [FW-1:0] fo, output int lat);
    int start = (src == 3) ? 0 : (2 - src);
    fo   = f;
    port = 3;
    lat  = 3 - start;
    for (int s = start; s < 3; s++) begin
      int d = 2 - s;
      logic signed [3:0] o = fo[d*4 +: 4];
      if (o != 0) begin
        o = (o > 0) ? o - 4'sd1 : o + 4'sd1;
        fo[d*4 +: 4] = o;
        port = d;
        lat  = s - start + 1;
        break;
      end
    end
  endtask

  function automatic bit in_rdy(input int s);
    return (s == 3) ? host_in_ready : link_in_ready[s];
  endfunction

  function automatic bit out_v(input int p);
    return (p == 3) ? host_out_valid : link_out_valid[p];
  endfunction

  function automatic bit out_r(input int p);
    return (p == 3) ? host_out_ready : link_out_ready[p];
  endfunction

  function automatic logic [FW-1:0] out_d(input int p);
    return (p == 3) ? host_out_data : link_out_data[p*FW +: FW];
  endfunction

  task automatic send(input int src, input logic [FW-1:0] f, input string req,
                      input bit timed, output int acc);
    int port, lat;
    logic [FW-1:0] fo;
    exp_t e;
    @(negedge clk);
    if (src == 3) begin host_in_valid = 1'b1; host_in_data = f; end
    else begin link_in_valid[src] = 1'b1; link_in_data[src*FW +: FW] = f; end
    #1;
    while (!in_rdy(src)) begin
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    model(src, f, port, fo, lat);
    e.port = port;
    e.flit = fo;
    e.due  = timed ? acc + lat - 1 : -1;
    e.req  = req;
    sbq.push_back(e);
    @(negedge clk);
    if (src == 3) host_in_valid = 1'b0;
    else link_in_valid[src] = 1'b0;
  endtask

  // Monitor: pops the oldest expectation for each port as results depart.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int p = 0; p < 4; p++) begin
        if (out_v(p) && out_r(p)) begin
          int idx = -1;
          for (int i = 0; i < sbq.size(); i++) begin
            if (sbq[i].port == p) begin idx = i; break; end
          end
          if (idx < 0) begin
            check(1'b0, "unexpected output", 32'(p), 32'hFFFF_FFFF);
          end else begin
            check(out_d(p) == sbq[idx].flit, sbq[idx].req, 32'(out_d(p)), 32'(sbq[idx].flit));
            if (sbq[idx].due >= 0)
              check(cyc == sbq[idx].due, sbq[idx].req, 32'(cyc), 32'(sbq[idx].due));
            sbq.delete(idx);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog", 32'(cyc), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int a, b;
    logic [FW-1:0] held;
    rst_n = 1'b0;
    host_in_valid = 1'b0; host_in_data = '0; host_out_ready = 1'b1;
    link_in_valid = '0; link_in_data = '0; link_out_ready = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R10
    check(host_out_valid == 1'b0, "R10 host_out_valid", 32'(host_out_valid), 32'd0);
    check(link_out_valid == 3'b000, "R10 link_out_valid", 32'(link_out_valid), 32'd0);
    check(host_in_ready == 1'b1, "R10 host_in_ready", 32'(host_in_ready), 32'd1);

    send(3, mk(8'hA1, 3, 1, 0), "R1 host to Z link", 1'b1, a);
    send(3, mk(8'hA2, -2, 0, 0), "R2 negative step", 1'b1, a);
    send(3, mk(8'hA3, 1, 2, 3), "R2 step to zero", 1'b1, a);
    send(3, mk(8'hA4, 0, -3, 2), "R4 Y after Z", 1'b1, a);
    send(3, mk(8'hA5, 0, 0, 5), "R4 X last", 1'b1, a);
    send(3, mk(8'hA6, 0, 0, 0), "R3 host to host", 1'b1, a);
    send(1, mk(8'hB1, 0, 2, 1), "R5 Y link continues", 1'b1, a);
    send(0, mk(8'hB2, 0, 0, -1), "R5 X link continues", 1'b1, a);
    send(1, mk(8'hB3, 0, 0, 0), "R6 Y link to host", 1'b1, a);
    send(2, mk(8'hB4, 0, 1, 0), "R6 Z link up to Y", 1'b1, a);
    repeat (5) @(negedge clk);

    fork
      send(2, mk(8'hC1, 2, 0, 0), "R7 link winner", 1'b1, a);
      send(3, mk(8'hC2, 1, 0, 0), "R7 stalled chain input", 1'b1, b);
    join
    check(b == a + 1, "R7 same-dim conflict", 32'(b), 32'(a + 1));
    repeat (5) @(negedge clk);
    fork
      send(2, mk(8'hC3, 0, 0, 0), "R7 link winner up", 1'b1, a);
      send(3, mk(8'hC4, 0, 0, 0), "R7 stalled up", 1'b1, b);
    join
    check(b == a + 1, "R7 up conflict", 32'(b), 32'(a + 1));
    repeat (5) @(negedge clk);
    fork
      send(3, mk(8'hD1, 1, 0, 0), "R8 chain to Z link", 1'b1, a);
      send(2, mk(8'hD2, 0, 0, 0), "R8 link up", 1'b1, b);
    join
    check(a == b, "R8 parallel accept", 32'(b), 32'(a));
    repeat (6) @(negedge clk);

    // R9 backpressure on the Z link output
    link_out_ready[2] = 1'b0;
    send(3, mk(8'hE1, 4, 0, 0), "R9 held flit", 1'b0, a);
    #1;
    held = link_out_data[2*FW +: FW];
    check(link_out_valid[2] == 1'b1, "R9 valid held", 32'(link_out_valid[2]), 32'd1);
    check(held == mk(8'hE1, 3, 0, 0), "R9 held data", 32'(held), 32'(mk(8'hE1, 3, 0, 0)));
    repeat (3) begin
      @(negedge clk);
      #1;
      check(link_out_valid[2] == 1'b1, "R9 still valid", 32'(link_out_valid[2]), 32'd1);
      check(link_out_data[2*FW +: FW] == held, "R9 stable data",
            32'(link_out_data[2*FW +: FW]), 32'(held));
    end
    fork
      send(3, mk(8'hE2, -1, 0, 0), "R9 second flit", 1'b0, b);
      begin
        @(negedge clk);
        @(negedge clk);
        #1;
        check(host_in_ready == 1'b0, "R9 full blocks input", 32'(host_in_ready), 32'd0);
        @(negedge clk);
        link_out_ready[2] = 1'b1;
      end
    join
    repeat (10) @(negedge clk);
    check(sbq.size() == 0, "all requirements drained", 32'(sbq.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule